// File: doc/BRIEF.md
# CRC-32 Final Residue Reducer

This block finishes a folded CRC-32 computation. An upstream folding engine leaves a 128-bit residue that is congruent to the running message. This block maps that residue `V` to `(V · x^32) mod P`, where `P(x)` is the 33-bit generator `0x104C11DB7` and bit 127 of the residue is the highest-degree coefficient. Bit reflection and the final complement are left to the surrounding logic.

The reduction takes four carry-less multiply-and-XOR steps. First, the 128-bit value is folded to 96 bits with the constant `x^96 mod P`. Next, the 96-bit value is folded to 64 bits with `x^64 mod P`. Last, a two-step Barrett reduction uses the quotient constant `floor(x^64 / P)` and then `P` itself. All four steps run one after another on a single carry-less multiplier, one step per clock. The fold and Barrett constants are derived from the polynomial parameter at elaboration time.

A caller pulses `start_i` with the residue on `residue_i` while `busy_o` is low. The result appears on `crc_o` together with a one-cycle `done_o`, four cycles after the start cycle. `crc_o` holds that value until the next completion.

Top module: `crc32_barrett_reducer`

## Requirements
- R1: After reset, and until the first completion, `busy_o` is 0, `done_o` is 0 and `crc_o` is 0.
- R2: A `start_i` sampled while `busy_o` is low makes `busy_o` high in the next cycle, and it stays high for exactly three cycles.
- R3: `done_o` is high for exactly one cycle, in the fourth cycle after the cycle in which the start was sampled, and `busy_o` is low in that cycle.
- R4: With `done_o` high, `crc_o` equals `(V · x^32) mod P` for `P = 0x104C11DB7`. Here `V` is the residue sampled with the accepted start, and `residue_i[127]` is the coefficient of x^127.
- R5: A `start_i` sampled while `busy_o` is high is ignored. The running reduction keeps its timing and returns the result for the residue it accepted.
- R6: `crc_o` changes only in a cycle where `done_o` is high. Changes on `residue_i` without an accepted start have no effect on it.
- R7: A start given in the same cycle as `done_o` is accepted. Back-to-back reductions therefore complete every four cycles.
- R8: Boundary residues: an all-zero residue gives 0, and a residue of 1 (only bit 0 set) gives `0x04C11DB7`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; accepted only while not busy |
| residue_i | input | 128 | Folded residue, sampled with an accepted start |
| busy_o | output | 1 | Reduction in progress |
| done_o | output | 1 | One-cycle completion strobe |
| crc_o | output | 32 | Reduced CRC, held between completions |

## Verification
The result is compared against a bit-serial long division of the residue followed by 32 zero bits. The two paths share no arithmetic, so any wrong fold or Barrett constant shows up as a mismatch. The zero residue and the single-bit residues at bit 0 and bit 127 separate the lowest-degree path, where only the x^32 shift and the Barrett steps act, from the highest-degree path, where the first fold constant dominates. The all-ones residue and random residues exercise every partial product at once. Back-to-back starts and starts that arrive while the block is busy, each with a different residue, separate a correct acceptance rule from a restart or from a late capture of the input.

// File: rtl/crc_red_pkg.sv
package crc_red_pkg;

  localparam int CRC_W = 32;

  typedef enum logic [1:0] {
    OP_FOLD1 = 2'd0,
    OP_FOLD2 = 2'd1,
    OP_BAR1  = 2'd2,
    OP_BAR2  = 2'd3
  } op_e;

  // x^n mod P, P given without its leading x^CRC_W term
  function automatic logic [CRC_W-1:0] xpow_mod(input int n, input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] r;
    r = {{(CRC_W-1){1'b0}}, 1'b1};
    for (int i = 0; i < n; i++) begin
      if (r[CRC_W-1]) r = {r[CRC_W-2:0], 1'b0} ^ poly;
      else            r = {r[CRC_W-2:0], 1'b0};
    end
    return r;
  endfunction

  // floor(x^(2*CRC_W) / P)
  function automatic logic [CRC_W:0] barrett_quot(input logic [CRC_W-1:0] poly);
    logic [CRC_W:0] rem;
    logic [CRC_W:0] q;
    logic           qb;
    rem = '0;
    q   = '0;
    for (int i = 2*CRC_W; i >= 0; i--) begin
      rem = {rem[CRC_W-1:0], (i == 2*CRC_W)};
      qb  = rem[CRC_W];
      if (qb) rem = rem ^ {1'b1, poly};
      q = {q[CRC_W-1:0], qb};
    end
    return q;
  endfunction

endpackage

// File: rtl/crc_clmul.sv
module crc_clmul #(
  parameter int A_W = 64,
  parameter int B_W = 33
) (
  input  logic [A_W-1:0]     a_i,
  input  logic [B_W-1:0]     b_i,
  output logic [A_W+B_W-2:0] p_o
);
  localparam int P_W = A_W + B_W - 1;

  logic [P_W-1:0] b_ext;
  assign b_ext = {{(P_W-B_W){1'b0}}, b_i};

  always_comb begin
    p_o = '0;
    for (int i = 0; i < A_W; i++) begin
      if (a_i[i]) p_o = p_o ^ (b_ext << i);
    end
  end
endmodule

// File: rtl/crc_seq_ctrl.sv
module crc_seq_ctrl
  import crc_red_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ld_o,
  output op_e  op_o,
  output logic busy_o,
  output logic done_o
);
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FOLD2 = 2'd1,
    ST_BAR1  = 2'd2,
    ST_BAR2  = 2'd3
  } st_e;

  st_e  st_q, st_d;
  logic done_q;

  always_comb begin
    st_d = st_q;
    op_o = OP_FOLD1;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_FOLD2;
      ST_FOLD2: begin op_o = OP_FOLD2; st_d = ST_BAR1; end
      ST_BAR1:  begin op_o = OP_BAR1;  st_d = ST_BAR2; end
      ST_BAR2:  begin op_o = OP_BAR2;  st_d = ST_IDLE; end
      default:  st_d = ST_IDLE;
    endcase
  end

  assign busy_o = (st_q != ST_IDLE);
  assign ld_o   = busy_o || start_i;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_BAR2);
    end
  end
endmodule

// File: rtl/crc_fold_path.sv
module crc_fold_path
  import crc_red_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7,
  parameter logic [CRC_W-1:0] K_HI = 32'h0,
  parameter logic [CRC_W-1:0] K_MID = 32'h0,
  parameter logic [CRC_W:0]   K_U  = 33'h0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ld_i,
  input  op_e                op_i,
  input  logic [4*CRC_W-1:0] res_i,
  output logic [CRC_W-1:0]   crc_o
);
  localparam int W   = CRC_W;
  localparam int A_W = 2*W;
  localparam int B_W = W + 1;
  localparam int P_W = A_W + B_W - 1;

  logic [3*W-1:0] w_q;   // 96-bit partial fold
  logic [2*W-1:0] r_q;   // degree < 2W residue
  logic [W-1:0]   t_q;   // upper half of Barrett estimate
  logic [W-1:0]   crc_q;

  logic [A_W-1:0] mul_a;
  logic [B_W-1:0] mul_b;
  logic [P_W-1:0] prod;

  always_comb begin
    unique case (op_i)
      OP_FOLD1: begin mul_a = res_i[4*W-1:2*W];           mul_b = {1'b0, K_HI};  end
      OP_FOLD2: begin mul_a = {{W{1'b0}}, w_q[3*W-1:2*W]}; mul_b = {1'b0, K_MID}; end
      OP_BAR1:  begin mul_a = {{W{1'b0}}, r_q[2*W-1:W]};   mul_b = K_U;           end
      default:  begin mul_a = {{W{1'b0}}, t_q};            mul_b = {1'b1, POLY};  end
    endcase
  end

  crc_clmul #(.A_W(A_W), .B_W(B_W)) u_mul (
    .a_i(mul_a),
    .b_i(mul_b),
    .p_o(prod)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q   <= '0;
      r_q   <= '0;
      t_q   <= '0;
      crc_q <= '0;
    end else if (ld_i) begin
      unique case (op_i)
        OP_FOLD1: w_q   <= prod ^ {res_i[2*W-1:0], {W{1'b0}}};
        OP_FOLD2: r_q   <= prod[2*W-1:0] ^ w_q[2*W-1:0];
        OP_BAR1:  t_q   <= prod[2*W-1:W];
        default:  crc_q <= r_q[W-1:0] ^ prod[W-1:0];
      endcase
    end
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/crc32_barrett_reducer.sv
module crc32_barrett_reducer
  import crc_red_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [4*CRC_W-1:0] residue_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [CRC_W-1:0]   crc_o
);
  localparam logic [CRC_W-1:0] K_HI  = xpow_mod(3*CRC_W, POLY);
  localparam logic [CRC_W-1:0] K_MID = xpow_mod(2*CRC_W, POLY);
  localparam logic [CRC_W:0]   K_U   = barrett_quot(POLY);

  logic ld;
  op_e  op;

  crc_seq_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .ld_o   (ld),
    .op_o   (op),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  crc_fold_path #(
    .POLY (POLY),
    .K_HI (K_HI),
    .K_MID(K_MID),
    .K_U  (K_U)
  ) u_path (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (ld),
    .op_i  (op),
    .res_i (residue_i),
    .crc_o (crc_o)
  );
endmodule

// File: rtl/crc_reducer_chk.sv
module crc_reducer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic [31:0] crc_o
);
  logic [2:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              busy_cnt <= '0;
    else if (!busy_o)         busy_cnt <= '0;
    else if (busy_cnt != 3'd7) busy_cnt <= busy_cnt + 3'd1;
  end

  // R2
  busy_from_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  // R2
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  // R5
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (busy_cnt < 3'd3));

  // R3
  done_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && busy_cnt == 3'd3));

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  crc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(crc_o));
endmodule

bind crc32_barrett_reducer crc_reducer_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .crc_o  (crc_o)
);

// File: tb/sim_crc32_barrett_reducer.sv
module sim_crc32_barrett_reducer;
  localparam logic [31:0] POLY = 32'h04C11DB7;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] residue_i = '0;
  logic         busy_o, done_o;
  logic [31:0]  crc_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [31:0] exp_q[$];
  int          due_q[$];
  logic [31:0] last_crc = '0;
  bit          finished = 0;

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  crc32_barrett_reducer u0 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .residue_i(residue_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .crc_o    (crc_o)
  );

  function automatic logic [31:0] ref_crc(input logic [127:0] v);
    logic [31:0] r;
    logic        top;
    r = '0;
    for (int i = 159; i >= 0; i--) begin
      top = r[31];
      r   = {r[30:0], (i >= 32) ? v[i-32] : 1'b0};
      if (top) r = r ^ POLY;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // driver: entered and left on a negedge; poke drives junk starts while busy
  task automatic run(input logic [127:0] v, input bit poke);
    start_i   = 1'b1;
    residue_i = v;
    exp_q.push_back(ref_crc(v));
    due_q.push_back(cyc + 4);
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk_i);
      start_i   = poke;
      residue_i = poke ? rnd128() : residue_i;
      chk("R2 busy during run", {63'd0, busy_o}, 64'd1);
    end
    start_i = 1'b0;
    @(negedge clk_i);
    chk("R2 busy ends after three cycles", {63'd0, busy_o}, 64'd0);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      if (done_o) begin
        if (exp_q.size() == 0) begin
          chk("R3 unexpected done", 64'd1, 64'd0);
        end else begin
          chk("R4 crc value", {32'd0, crc_o}, {32'd0, exp_q.pop_front()});
          chk("R3 done cycle", 64'(cyc), 64'(due_q.pop_front()));
        end
        last_crc = crc_o;
      end else if (crc_o !== last_crc) begin
        chk("R6 crc changed without done", {32'd0, crc_o}, {32'd0, last_crc});
        last_crc = crc_o;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    $display("FAIL watchdog: actual timeout expected completion");
    checks++;
    fails++;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    chk("R1 busy in reset", {63'd0, busy_o}, 64'd0);
    chk("R1 done in reset", {63'd0, done_o}, 64'd0);
    chk("R1 crc in reset", {32'd0, crc_o}, 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 idle after reset", {62'd0, busy_o, done_o}, 64'd0);

    // R8 boundaries
    chk("R8 reference of one", {32'd0, ref_crc(128'd1)}, {32'd0, POLY});
    run(128'd0, 0);
    chk("R8 zero residue", {32'd0, crc_o}, 64'd0);
    run(128'd1, 0);
    chk("R8 unit residue", {32'd0, crc_o}, {32'd0, POLY});
    run({1'b1, 127'd0}, 0);
    run({128{1'b1}}, 0);
    run({64'd0, {64{1'b1}}}, 0);

    // R4 random with idle gaps; R6 input wiggles while idle
    for (int n = 0; n < 20; n++) begin
      run(rnd128(), 0);
      for (int g = 0; g < 5; g++) begin
        residue_i = rnd128();
        @(negedge clk_i);
      end
    end

    // R7 back-to-back
    for (int n = 0; n < 12; n++) run(rnd128(), 0);

    // R5 starts while busy are ignored
    for (int n = 0; n < 8; n++) run(rnd128(), 1);
    for (int n = 0; n < 4; n++) begin
      run(rnd128(), 1);
      repeat (3) @(negedge clk_i);
    end

    repeat (6) @(negedge clk_i);
    chk("R3 all results returned", 64'(exp_q.size()), 64'd0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule